// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core

This block is a small 32-bit processor that finishes every instruction in the clock cycle in which it is fetched. Each cycle it presents the program counter on the instruction port and decodes the returned word with combinational logic. It reads two operands from a 32-entry register file, forms a sum, a product or a memory address, and returns its result to the register file at the next rising edge. The new program counter is taken at the same edge.

Both memory ports are combinational. The instruction word and the load data must be valid within the same cycle as the address that requests them. The core supports register add, add immediate, multiply, load word, store word, jump, jump-and-link, jump via register, branch-if-not-equal, and a post-incrementing load. The post-incrementing load writes the register file twice in one cycle. Branches and jumps have no delay slot.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, `dmem_we` is 0 and no register is written. The first rising edge with `rst_n` low sets `imem_addr` to 0x00000200.
- R2: Every instruction that is not a branch or a jump moves the PC to PC+4. An unknown opcode (for example 111111) acts as a no-op.
- R3: addu (opcode 000000, funct 100001, fields rs[25:21] rt[20:16] rd[15:11]) writes R[rs]+R[rt] to rd. addiu (opcode 001001) writes R[rs]+sext(imm[15:0]) to rt. Both wrap modulo 2^32.
- R4: mul (opcode 011100, funct 000010) writes the low 32 bits of R[rs]*R[rt] to rd.
- R5: lw (100011) and sw (101011) drive `dmem_addr` with R[rs]+sext(imm). sw drives `dmem_wdata` with R[rt] and raises `dmem_we`. No other instruction raises `dmem_we`. lw writes `dmem_rdata` to rt.
- R6: The post-incrementing load (opcode 100111) loads M[R[rs]+sext(imm)] into rt and writes R[rs]+4 into rs in the same cycle. If rt equals rs, the loaded data is what remains.
- R7: Register 0 reads as zero, and writes to it are discarded.
- R8: bne (000101) goes to PC+4+sext(imm)*4 when R[rs]!=R[rt]. Otherwise it goes to PC+4.
- R9: j (000010) and jal (000011) go to {PC+4[31:28], target[25:0], 00}. jal also writes PC+4 into register 31. jr (000000, funct 001000) goes to R[rs].
- R10: An R-type word (opcode 000000 or 011100) with a nonzero shamt field [10:6] acts as a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 32 | Current program counter |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Effective data address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe for this cycle |
| dmem_rdata | input | 32 | Load data at `dmem_addr` |

## Verification
The hardest case to reach is the post-incrementing load. Its two writes in one cycle can only be observed by later instructions. The stimulus therefore stores both registers afterwards, first with distinct rt and rs and then with rt equal to rs. Register contents in general are exposed by following every computation with a store and checking the store data at the port. The bench itself plays the role of instruction memory, stepping through a table. As a result, branches and jumps are checked purely through the addresses the core fetches next.

// File: rtl/sc_core.sv
module sc_core #(
  parameter logic [31:0] RESET_PC = 32'h0000_0200
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);
  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_MULG  = 6'b011100;
  localparam logic [5:0] OP_ADDIU = 6'b001001;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_LWINC = 6'b100111;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_J     = 6'b000010;
  localparam logic [5:0] OP_JAL   = 6'b000011;
  localparam logic [5:0] OP_BNE   = 6'b000101;
  localparam logic [5:0] FN_ADDU  = 6'b100001;
  localparam logic [5:0] FN_JR    = 6'b001000;
  localparam logic [5:0] FN_MUL   = 6'b000010;

  localparam logic [1:0] NPC_SEQ = 2'd0;
  localparam logic [1:0] NPC_JMP = 2'd1;
  localparam logic [1:0] NPC_REG = 2'd2;
  localparam logic [1:0] NPC_BR  = 2'd3;

  localparam logic [1:0] WB_ALU = 2'd0;
  localparam logic [1:0] WB_MUL = 2'd1;
  localparam logic [1:0] WB_MEM = 2'd2;
  localparam logic [1:0] WB_LNK = 2'd3;

  logic [31:0] pc;
  logic [31:0] rf [32];

  wire [5:0]  opc   = imem_data[31:26];
  wire [4:0]  f_rs  = imem_data[25:21];
  wire [4:0]  f_rt  = imem_data[20:16];
  wire [4:0]  f_rd  = imem_data[15:11];
  wire [4:0]  f_sh  = imem_data[10:6];
  wire [5:0]  f_fn  = imem_data[5:0];
  wire [31:0] simm  = {{16{imem_data[15]}}, imem_data[15:0]};

  wire [31:0] rs_val = (f_rs == 5'd0) ? 32'd0 : rf[f_rs];
  wire [31:0] rt_val = (f_rt == 5'd0) ? 32'd0 : rf[f_rt];

  logic [1:0] pc_sel;
  logic       op1_sel;
  logic [1:0] wb_sel;
  logic [4:0] waddr;
  logic       wen;
  logic       st_en;
  logic       inc_en;

  always_comb begin
    pc_sel  = NPC_SEQ;
    op1_sel = 1'b0;
    wb_sel  = WB_ALU;
    waddr   = f_rt;
    wen     = 1'b0;
    st_en   = 1'b0;
    inc_en  = 1'b0;
    unique case (opc)
      OP_RTYPE: if (f_sh == 5'd0) begin
        if (f_fn == FN_ADDU) begin
          waddr = f_rd;
          wen   = 1'b1;
        end else if (f_fn == FN_JR) begin
          pc_sel = NPC_REG;
        end
      end
      OP_MULG: if (f_sh == 5'd0 && f_fn == FN_MUL) begin
        wb_sel = WB_MUL;
        waddr  = f_rd;
        wen    = 1'b1;
      end
      OP_ADDIU: begin
        op1_sel = 1'b1;
        wen     = 1'b1;
      end
      OP_LW: begin
        op1_sel = 1'b1;
        wb_sel  = WB_MEM;
        wen     = 1'b1;
      end
      OP_LWINC: begin
        op1_sel = 1'b1;
        wb_sel  = WB_MEM;
        wen     = 1'b1;
        inc_en  = 1'b1;
      end
      OP_SW: begin
        op1_sel = 1'b1;
        st_en   = 1'b1;
      end
      OP_J:   pc_sel = NPC_JMP;
      OP_JAL: begin
        pc_sel = NPC_JMP;
        wb_sel = WB_LNK;
        waddr  = 5'd31;
        wen    = 1'b1;
      end
      OP_BNE: if (rs_val != rt_val) pc_sel = NPC_BR;
      default: ;
    endcase
  end

  wire [31:0] pc4     = pc + 32'd4;
  wire [31:0] alu_b   = op1_sel ? simm : rt_val;
  wire [31:0] alu_out = rs_val + alu_b;
  wire [31:0] mul_out = rs_val * rt_val;
  wire [31:0] j_targ  = {pc4[31:28], imem_data[25:0], 2'b00};
  wire [31:0] br_targ = pc4 + {simm[29:0], 2'b00};

  logic [31:0] wb_data;
  always_comb begin
    unique case (wb_sel)
      WB_MUL:  wb_data = mul_out;
      WB_MEM:  wb_data = dmem_rdata;
      WB_LNK:  wb_data = pc4;
      default: wb_data = alu_out;
    endcase
  end

  logic [31:0] pc_next;
  always_comb begin
    unique case (pc_sel)
      NPC_JMP: pc_next = j_targ;
      NPC_REG: pc_next = rs_val;
      NPC_BR:  pc_next = br_targ;
      default: pc_next = pc4;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc <= RESET_PC;
    else        pc <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (rst_n) begin
      if (inc_en && f_rs != 5'd0) rf[f_rs] <= rs_val + 32'd4;
      if (wen && waddr != 5'd0)   rf[waddr] <= wb_data;
    end
  end

  assign imem_addr  = pc;
  assign dmem_addr  = alu_out;
  assign dmem_wdata = rt_val;
  assign dmem_we    = st_en & rst_n;
endmodule

module sc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] imem_addr,
  input logic [31:0] imem_data,
  input logic        dmem_we
);
  wire [5:0] opc = imem_data[31:26];
  wire seq_op = opc == 6'b001001 || opc == 6'b100011 || opc == 6'b101011 ||
                opc == 6'b100111 || opc == 6'b111111;

  a_r1_reset_pc: assert property (@(posedge clk) !rst_n |=> imem_addr == 32'h0000_0200);
  a_r1_no_store_in_reset: assert property (@(posedge clk) !rst_n |-> !dmem_we);
  a_r5_store_only_sw: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> opc == 6'b101011);
  a_r2_seq_advance: assert property (@(posedge clk) disable iff (!rst_n)
    seq_op |=> imem_addr == $past(imem_addr) + 32'd4);
  a_r9_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == 6'b000010 || opc == 6'b000011) |=> imem_addr[27:0] == {$past(imem_data[25:0]), 2'b00});
endmodule

bind sc_core sc_core_chk u_sc_core_chk (
  .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr),
  .imem_data(imem_data), .dmem_we(dmem_we)
);

// File: tb/test_sc_core.sv
module test_sc_core;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] instr;
    logic [31:0] rdata;
    logic [31:0] pc;
    logic        we;
    logic        chk_addr;
    logic [31:0] addr;
    logic [31:0] wdata;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t TBL [NV] = '{
    '{32'h24010005, 32'h0, 32'h200, 1'b0, 1'b0, 32'h0,        32'h0},        // R3 addiu r1=5
    '{32'h2402FFFD, 32'h0, 32'h204, 1'b0, 1'b0, 32'h0,        32'h0},        // R3 addiu r2=-3
    '{32'h00221821, 32'h0, 32'h208, 1'b0, 1'b0, 32'h0,        32'h0},        // R3 addu r3=2
    '{32'hAC230010, 32'h0, 32'h20C, 1'b1, 1'b1, 32'h15,       32'h2},        // R5 sw r3
    '{32'h70222002, 32'h0, 32'h210, 1'b0, 1'b0, 32'h0,        32'h0},        // R4 mul r4=-15
    '{32'hAC44FFFC, 32'h0, 32'h214, 1'b1, 1'b1, 32'hFFFFFFF9, 32'hFFFFFFF1}, // R4 R5 neg offset
    '{32'h8C250008, 32'hCAFE0000, 32'h218, 1'b0, 1'b1, 32'hD, 32'h0},        // R5 lw r5
    '{32'hAC050000, 32'h0, 32'h21C, 1'b1, 1'b1, 32'h0,        32'hCAFE0000}, // R5 load data
    '{32'h9C260004, 32'h11, 32'h220, 1'b0, 1'b1, 32'h9,       32'h0},        // R6 lw.ai r6,4(r1)
    '{32'hACC10000, 32'h0, 32'h224, 1'b1, 1'b1, 32'h11,       32'h9},        // R6 both writes
    '{32'h9C210000, 32'h77, 32'h228, 1'b0, 1'b1, 32'h9,       32'h0},        // R6 rt==rs
    '{32'hAC010000, 32'h0, 32'h22C, 1'b1, 1'b1, 32'h0,        32'h77},       // R6 data wins
    '{32'h24000007, 32'h0, 32'h230, 1'b0, 1'b0, 32'h0,        32'h0},        // R7 write r0
    '{32'hAC000000, 32'h0, 32'h234, 1'b1, 1'b1, 32'h0,        32'h0},        // R7 r0 reads 0
    '{32'h14200002, 32'h0, 32'h238, 1'b0, 1'b0, 32'h0,        32'h0},        // R8 bne taken
    '{32'h14210005, 32'h0, 32'h244, 1'b0, 1'b0, 32'h0,        32'h0},        // R8 bne not taken
    '{32'h0C0000C0, 32'h0, 32'h248, 1'b0, 1'b0, 32'h0,        32'h0},        // R9 jal
    '{32'hAC1F0000, 32'h0, 32'h300, 1'b1, 1'b1, 32'h0,        32'h24C},      // R9 link
    '{32'h24070400, 32'h0, 32'h304, 1'b0, 1'b0, 32'h0,        32'h0},
    '{32'h00E00008, 32'h0, 32'h308, 1'b0, 1'b0, 32'h0,        32'h0},        // R9 jr
    '{32'h08000082, 32'h0, 32'h400, 1'b0, 1'b0, 32'h0,        32'h0},        // R9 j
    '{32'hFC000000, 32'h0, 32'h208, 1'b0, 1'b0, 32'h0,        32'h0},        // R2 unknown op
    '{32'h00000861, 32'h0, 32'h20C, 1'b0, 1'b0, 32'h0,        32'h0},        // R10 shamt!=0
    '{32'hAC010000, 32'h0, 32'h210, 1'b1, 1'b1, 32'h0,        32'h77},       // R10 r1 kept
    '{32'h24080001, 32'h0, 32'h214, 1'b0, 1'b0, 32'h0,        32'h0},
    '{32'h1500FFFF, 32'h0, 32'h218, 1'b0, 1'b0, 32'h0,        32'h0},        // R8 back branch
    '{32'hAC080000, 32'h0, 32'h218, 1'b1, 1'b1, 32'h0,        32'h1}         // R8 target
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_core i_sc_core (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    imem_data = 32'h0;
    dmem_rdata = 32'h0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset pc", imem_addr, 32'h200);
    imem_data = 32'hAC010000;
    #1 check("R1 no store in reset", {31'd0, dmem_we}, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      imem_data  = TBL[i].instr;
      dmem_rdata = TBL[i].rdata;
      #1;
      check($sformatf("R2 pc step %0d", i), imem_addr, TBL[i].pc);
      check($sformatf("R5 we step %0d", i), {31'd0, dmem_we}, {31'd0, TBL[i].we});
      if (TBL[i].chk_addr) check($sformatf("R5 addr step %0d", i), dmem_addr, TBL[i].addr);
      if (TBL[i].we) check($sformatf("R3 data step %0d", i), dmem_wdata, TBL[i].wdata);
      @(negedge clk);
    end
    imem_data = 32'hAC010000;
    rst_n = 1'b0;
    #1 check("R1 store masked in reset", {31'd0, dmem_we}, 32'd0);
    @(negedge clk);
    check("R1 pc reloaded", imem_addr, 32'h200);
    rst_n = 1'b1;
    imem_data = 32'h00000000;
    @(negedge clk);
    check("R2 nop advance", imem_addr, 32'h204);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule